// File: doc/BRIEF.md
# Six-Entry In-Order Completion Queue

This block keeps every dispatched instruction in program order until it finishes. The dispatch stage claims up to two entries per cycle on two allocation lanes. Lane 0 holds the older of the pair. Each allocation returns the index of the slot it took. An execution unit later reports completion on one of two finish lanes by quoting that index, and can flag an exception at the same time. The queue then retires finished entries from its head, at most two per cycle and never out of order. Each retirement presents the entry's destination rename tag, and the register file uses it to commit the value to architectural state.

A finished entry that carries an exception never commits. When it reaches the head, the block raises a one-cycle flush and discards that entry together with every younger one. The front end can then restart from a precise point after a mispredicted branch or a fault. The count of free slots is an output, so the dispatch arbiter can tell in advance whether a pair will fit.

Allocation uses valid/ready. A lane is accepted on a rising edge when its valid and ready are both high, and a valid without ready is dropped without effect. Dispatch must hold lane 1 valid only when lane 0 is valid. Ready comes from the occupancy at the start of the cycle, so entries retiring in the same cycle do not widen it. Retirement and finish reports are plain pulses with no back-pressure, because the register file always accepts a commit.

Top module: `cmpl_queue`

## Requirements
- R1: The queue holds DEPTH entries (default 6). `free_cnt` equals DEPTH minus the number of occupied entries, reads 6 after reset, and updates on the edge that accepts allocations or retires entries.
- R2: `alloc_ready[0]` is high when `free_cnt` is at least 1 and `alloc_ready[1]` is high when `free_cnt` is at least 2; both are low in any cycle in which `flush` is high. A lane whose valid is high while its ready is low changes nothing.
- R3: An accepted lane-0 allocation takes the slot shown on `alloc_idx0`, which is the current tail. Lane 1 takes the slot shown on `alloc_idx1`, which is the next index. Indices advance by one per accepted allocation, wrap from DEPTH-1 to 0, and lane 1 is accepted only together with lane 0.
- R4: A finish report on either lane (`fin_valid[k]`, `fin_idx`k, `fin_exc[k]`) marks the occupied entry at that index finished from the next edge on. A report naming an unoccupied slot is ignored, so an entry later allocated into that slot starts unfinished.
- R5: When the head entry is finished without exception, `ret_valid[0]` is high with `ret_tag0` equal to its tag. `ret_valid[1]` is high with `ret_tag1` equal to the second-oldest entry's tag only when that entry is also finished without exception. `ret_valid` reads 2'b01 or 2'b11, never 2'b10. Retired entries leave the queue on the next edge.
- R6: While the head entry is not finished, `ret_valid` is 2'b00 and `flush` is low, however many younger entries have finished.
- R7: When the head entry is finished with its exception flag set, `flush` is high and `ret_valid` is 2'b00 for that cycle. On the next edge the queue becomes empty, and the next allocation receives the flushed head's index.
- R8: If the second-oldest entry finished with an exception while the head finished cleanly, only the head retires (`ret_valid` = 2'b01). The excepting entry then becomes head and flushes in the following cycle.
- R9: Retire tags come out in the exact order, and with the exact values, that the matching allocations supplied on `alloc_tag0`/`alloc_tag1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 2 | Allocation request per lane, bit 0 oldest |
| alloc_ready | output | 2 | Allocation room per lane |
| alloc_tag0 | input | TAG_W | Destination rename tag, lane 0 |
| alloc_tag1 | input | TAG_W | Destination rename tag, lane 1 |
| alloc_idx0 | output | IDX_W | Slot index granted to lane 0 |
| alloc_idx1 | output | IDX_W | Slot index granted to lane 1 |
| fin_valid | input | 2 | Finish report per lane |
| fin_idx0 | input | IDX_W | Slot finished on lane 0 |
| fin_idx1 | input | IDX_W | Slot finished on lane 1 |
| fin_exc | input | 2 | Exception flag per finish lane |
| ret_valid | output | 2 | Commit strobe, bit 0 = head |
| ret_tag0 | output | TAG_W | Tag committed by the head |
| ret_tag1 | output | TAG_W | Tag committed by the second-oldest entry |
| flush | output | 1 | Head had an exception; all entries discarded |
| free_cnt | output | CNT_W | Number of unoccupied slots |

## Verification
The assertions assume that dispatch never raises lane 1 without lane 0, and that a finish report names only an occupied slot that is not retiring in that cycle. The bench drives lane 1 only beside lane 0. It aims finish reports at live entries, except for the one deliberate report at a free slot that R4 calls for. That report is sent while the queue is empty, so no retirement can coincide with it. The bench also holds `alloc_valid` high against a full queue and during a flush cycle, to show that acceptance follows ready alone.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ONE   = 2'd1,
    ACT_TWO   = 2'd2,
    ACT_FLUSH = 2'd3
  } ret_act_e;
endpackage

// File: rtl/cq_ptrs.sv
module cq_ptrs
  import cq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       n_alloc,
  input  ret_act_e         act,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] second_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W-1:0] tail1_idx,
  output logic [CNT_W-1:0] free_cnt
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] used_q;
  logic [1:0]       n_ret;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return IDX_W'(s);
  endfunction

  always_comb begin
    case (act)
      ACT_ONE: n_ret = 2'd1;
      ACT_TWO: n_ret = 2'd2;
      default: n_ret = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
    end else if (act == ACT_FLUSH) begin
      tail_q <= head_q;
      used_q <= '0;
    end else begin
      head_q <= step_idx(head_q, int'(n_ret));
      tail_q <= step_idx(tail_q, int'(n_alloc));
      used_q <= used_q + CNT_W'(n_alloc) - CNT_W'(n_ret);
    end
  end

  assign head_idx   = head_q;
  assign second_idx = step_idx(head_q, 1);
  assign tail_idx   = tail_q;
  assign tail1_idx  = step_idx(tail_q, 1);
  assign free_cnt   = CNT_W'(DEPTH) - used_q;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CNT_W'(DEPTH));
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(n_alloc) <= free_cnt);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_FLUSH |=> free_cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/cq_slots.sv
module cq_slots #(
  parameter int DEPTH = 6,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       we,
  input  logic [IDX_W-1:0] wr_idx0,
  input  logic [IDX_W-1:0] wr_idx1,
  input  logic [TAG_W-1:0] wr_tag0,
  input  logic [TAG_W-1:0] wr_tag1,
  input  logic [1:0]       fin_valid,
  input  logic [IDX_W-1:0] fin_idx0,
  input  logic [IDX_W-1:0] fin_idx1,
  input  logic [1:0]       fin_exc,
  input  logic             clr_head,
  input  logic             clr_second,
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] second_idx,
  input  logic             flush,
  output logic [DEPTH-1:0] slot_vld,
  output logic [DEPTH-1:0] slot_fin,
  output logic [DEPTH-1:0] slot_exc,
  output logic [TAG_W-1:0] slot_tag [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit0, hit1, clr, set0, set1;
    assign hit0 = fin_valid[0] && fin_idx0 == IDX_W'(i) && slot_vld[i];
    assign hit1 = fin_valid[1] && fin_idx1 == IDX_W'(i) && slot_vld[i];
    assign clr  = (clr_head && head_idx == IDX_W'(i)) ||
                  (clr_second && second_idx == IDX_W'(i));
    assign set0 = we[0] && wr_idx0 == IDX_W'(i);
    assign set1 = we[1] && wr_idx1 == IDX_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_vld[i] <= 1'b0;
        slot_fin[i] <= 1'b0;
        slot_exc[i] <= 1'b0;
        slot_tag[i] <= '0;
      end else if (flush) begin
        slot_vld[i] <= 1'b0;
        slot_fin[i] <= 1'b0;
        slot_exc[i] <= 1'b0;
      end else if (clr) begin
        slot_vld[i] <= 1'b0;
        slot_fin[i] <= 1'b0;
        slot_exc[i] <= 1'b0;
      end else if (set0 || set1) begin
        slot_vld[i] <= 1'b1;
        slot_fin[i] <= 1'b0;
        slot_exc[i] <= 1'b0;
        slot_tag[i] <= set0 ? wr_tag0 : wr_tag1;
      end else if (hit0 || hit1) begin
        slot_fin[i] <= 1'b1;
        slot_exc[i] <= slot_exc[i] | (hit0 & fin_exc[0]) | (hit1 & fin_exc[1]);
      end
    end

    assert_fin_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_fin[i] |-> slot_vld[i]);
    assert_alloc_free_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set0 || set1) |-> !slot_vld[i]);
  end
endmodule

// File: rtl/cq_retire_sel.sv
module cq_retire_sel
  import cq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     h_vld,
  input  logic     h_fin,
  input  logic     h_exc,
  input  logic     s_vld,
  input  logic     s_fin,
  input  logic     s_exc,
  output ret_act_e act,
  output logic [1:0] ret_valid
);
  always_comb begin
    act = ACT_IDLE;
    if (h_vld && h_fin) begin
      if (h_exc)                        act = ACT_FLUSH;
      else if (s_vld && s_fin && !s_exc) act = ACT_TWO;
      else                              act = ACT_ONE;
    end
  end

  assign ret_valid = {act == ACT_TWO, act == ACT_ONE || act == ACT_TWO};

  assert_in_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[1] |-> ret_valid[0]);
endmodule

// File: rtl/cmpl_queue.sv
module cmpl_queue
  import cq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       alloc_valid,
  output logic [1:0]       alloc_ready,
  input  logic [TAG_W-1:0] alloc_tag0,
  input  logic [TAG_W-1:0] alloc_tag1,
  output logic [IDX_W-1:0] alloc_idx0,
  output logic [IDX_W-1:0] alloc_idx1,
  input  logic [1:0]       fin_valid,
  input  logic [IDX_W-1:0] fin_idx0,
  input  logic [IDX_W-1:0] fin_idx1,
  input  logic [1:0]       fin_exc,
  output logic [1:0]       ret_valid,
  output logic [TAG_W-1:0] ret_tag0,
  output logic [TAG_W-1:0] ret_tag1,
  output logic             flush,
  output logic [CNT_W-1:0] free_cnt
);
  ret_act_e         act;
  logic [1:0]       acc, n_alloc;
  logic [IDX_W-1:0] head_idx, second_idx, tail_idx, tail1_idx;
  logic [DEPTH-1:0] slot_vld, slot_fin, slot_exc;
  logic [TAG_W-1:0] slot_tag [DEPTH];

  assign flush          = act == ACT_FLUSH;
  assign alloc_ready[0] = !flush && free_cnt >= CNT_W'(1);
  assign alloc_ready[1] = !flush && free_cnt >= CNT_W'(2);
  assign acc[0]  = alloc_valid[0] && alloc_ready[0];
  assign acc[1]  = alloc_valid[1] && alloc_ready[1] && acc[0];
  assign n_alloc = {1'b0, acc[0]} + {1'b0, acc[1]};
  assign alloc_idx0 = tail_idx;
  assign alloc_idx1 = tail1_idx;
  assign ret_tag0 = slot_tag[head_idx];
  assign ret_tag1 = slot_tag[second_idx];

  cq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk, .rst_n, .n_alloc, .act,
    .head_idx, .second_idx, .tail_idx, .tail1_idx, .free_cnt
  );

  cq_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_slots (
    .clk, .rst_n,
    .we(acc), .wr_idx0(tail_idx), .wr_idx1(tail1_idx),
    .wr_tag0(alloc_tag0), .wr_tag1(alloc_tag1),
    .fin_valid, .fin_idx0, .fin_idx1, .fin_exc,
    .clr_head(ret_valid[0]), .clr_second(ret_valid[1]),
    .head_idx, .second_idx, .flush,
    .slot_vld, .slot_fin, .slot_exc, .slot_tag
  );

  cq_retire_sel u_sel (
    .clk, .rst_n,
    .h_vld(slot_vld[head_idx]), .h_fin(slot_fin[head_idx]), .h_exc(slot_exc[head_idx]),
    .s_vld(slot_vld[second_idx]), .s_fin(slot_fin[second_idx]), .s_exc(slot_exc[second_idx]),
    .act, .ret_valid
  );

  assert_lane_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid[1] |-> alloc_valid[0]);
  assert_head_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_fin[head_idx] |-> (ret_valid == 2'b00 && !flush));
  assert_flush_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid == 2'b00 && alloc_ready == 2'b00));
  assert_retire_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid != 2'b00 && alloc_valid == 2'b00) |=> free_cnt > $past(free_cnt));
endmodule

// File: tb/cmpl_queue_bench.sv
module cmpl_queue_bench;
  localparam int DEPTH = 6;
  localparam int TAG_W = 6;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] alloc_valid = '0, alloc_ready, fin_valid = '0, fin_exc = '0, ret_valid;
  logic [TAG_W-1:0] alloc_tag0 = '0, alloc_tag1 = '0, ret_tag0, ret_tag1;
  logic [IDX_W-1:0] alloc_idx0, alloc_idx1, fin_idx0 = '0, fin_idx1 = '0;
  logic flush;
  logic [CNT_W-1:0] free_cnt;

  always #10 clk = ~clk;

  cmpl_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_cmpl_queue (.*);

  int total = 0, fails = 0;
  int m_head = 0, m_tail = 0, m_cnt = 0;
  int m_tag [DEPTH];
  bit done = 0;

  function automatic int wrap(input int p, input int k);
    return (p + k) % DEPTH;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input int n, input int ta, input int tb);
    alloc_valid = (n == 2) ? 2'b11 : 2'b01;
    alloc_tag0 = TAG_W'(ta);
    alloc_tag1 = TAG_W'(tb);
    #1;
    check("R3 lane0 index", int'(alloc_idx0), m_tail);
    if (n == 2) check("R3 lane1 index", int'(alloc_idx1), wrap(m_tail, 1));
    cyc();
    alloc_valid = '0;
    m_tag[m_tail] = ta;
    if (n == 2) m_tag[wrap(m_tail, 1)] = tb;
    m_tail = wrap(m_tail, n);
    m_cnt += n;
    check("R1 free after alloc", int'(free_cnt), DEPTH - m_cnt);
  endtask

  task automatic fin(input int n, input int i0, input bit e0, input int i1, input bit e1);
    fin_valid = (n == 2) ? 2'b11 : 2'b01;
    fin_idx0 = IDX_W'(i0);
    fin_exc[0] = e0;
    fin_idx1 = IDX_W'(i1);
    fin_exc[1] = e1;
    cyc();
    fin_valid = '0;
    fin_exc = '0;
  endtask

  task automatic expect_retire(input int n);
    check("R5 ret_valid", int'(ret_valid), (n == 2) ? 3 : 1);
    check("R9 ret_tag0", int'(ret_tag0), m_tag[m_head]);
    if (n == 2) check("R9 ret_tag1", int'(ret_tag1), m_tag[wrap(m_head, 1)]);
    check("R5 no flush", int'(flush), 0);
    cyc();
    m_head = wrap(m_head, n);
    m_cnt -= n;
    check("R1 free after retire", int'(free_cnt), DEPTH - m_cnt);
  endtask

  task automatic drain();
    while (m_cnt > 0) begin
      if (m_cnt >= 2) begin
        fin(2, m_head, 0, wrap(m_head, 1), 0);
        expect_retire(2);
      end else begin
        fin(1, m_head, 0, 0, 0);
        expect_retire(1);
      end
    end
  endtask

  task automatic t_reset();
    check("R1 reset free", int'(free_cnt), DEPTH);
    check("R2 reset ready", int'(alloc_ready), 3);
    check("R5 reset ret", int'(ret_valid), 0);
    check("R7 reset flush", int'(flush), 0);
  endtask

  task automatic t_basic();
    alloc(2, 'h11, 'h12);
    fin(1, wrap(m_head, 1), 0, 0, 0);
    check("R6 head unfinished blocks", int'(ret_valid), 0);
    check("R6 no flush", int'(flush), 0);
    fin(1, m_head, 0, 0, 0);
    expect_retire(2);
  endtask

  task automatic t_single();
    alloc(2, 'h21, 'h22);
    fin(1, m_head, 0, 0, 0);
    expect_retire(1);
    fin(1, m_head, 0, 0, 0);
    expect_retire(1);
  endtask

  task automatic t_full();
    alloc(2, 'h31, 'h32);
    alloc(2, 'h33, 'h34);
    alloc(2, 'h35, 'h36);
    check("R2 full ready", int'(alloc_ready), 0);
    alloc_valid = 2'b11;
    alloc_tag0 = 'h3f;
    alloc_tag1 = 'h3e;
    cyc();
    alloc_valid = '0;
    check("R2 ignored when full", int'(free_cnt), 0);
    fin(2, wrap(m_head, 4), 0, wrap(m_head, 5), 0);
    fin(2, wrap(m_head, 2), 0, wrap(m_head, 3), 0);
    check("R6 younger finished still blocked", int'(ret_valid), 0);
    fin(2, m_head, 0, wrap(m_head, 1), 0);
    expect_retire(2);
    expect_retire(2);
    expect_retire(2);
  endtask

  task automatic t_ready_one();
    alloc(2, 'h01, 'h02);
    alloc(2, 'h03, 'h04);
    alloc(1, 'h05, 0);
    check("R2 one free ready", int'(alloc_ready), 1);
    alloc_valid = 2'b11;
    alloc_tag0 = 'h06;
    alloc_tag1 = 'h07;
    #1;
    check("R3 lane0 index at one free", int'(alloc_idx0), m_tail);
    cyc();
    alloc_valid = '0;
    m_tag[m_tail] = 'h06;
    m_tail = wrap(m_tail, 1);
    m_cnt += 1;
    check("R2 only lane0 accepted", int'(free_cnt), 0);
    drain();
  endtask

  task automatic t_flush_head();
    alloc(2, 'h0a, 'h0b);
    alloc(1, 'h0c, 0);
    fin(2, m_head, 1, wrap(m_head, 1), 0);
    check("R7 flush raised", int'(flush), 1);
    check("R7 no commit on flush", int'(ret_valid), 0);
    check("R2 ready low during flush", int'(alloc_ready), 0);
    alloc_valid = 2'b01;
    alloc_tag0 = 'h2a;
    cyc();
    alloc_valid = '0;
    check("R7 queue empty after flush", int'(free_cnt), DEPTH);
    check("R7 flush is one cycle", int'(flush), 0);
    m_tail = m_head;
    m_cnt = 0;
    alloc(1, 'h0d, 0);
    drain();
  endtask

  task automatic t_flush_second();
    alloc(2, 'h14, 'h15);
    fin(2, m_head, 0, wrap(m_head, 1), 1);
    check("R8 head retires alone", int'(ret_valid), 1);
    check("R8 head tag", int'(ret_tag0), m_tag[m_head]);
    check("R8 no flush yet", int'(flush), 0);
    cyc();
    m_head = wrap(m_head, 1);
    m_cnt -= 1;
    check("R8 flush next cycle", int'(flush), 1);
    check("R8 no commit", int'(ret_valid), 0);
    cyc();
    m_tail = m_head;
    m_cnt = 0;
    check("R8 empty after flush", int'(free_cnt), DEPTH);
    alloc(1, 'h16, 0);
    drain();
  endtask

  task automatic t_stale_finish();
    fin(1, m_tail, 0, 0, 0);
    alloc(1, 'h19, 0);
    check("R4 stale finish ignored", int'(ret_valid), 0);
    cyc();
    check("R4 entry still held", int'(free_cnt), DEPTH - 1);
    fin(1, m_head, 0, 0, 0);
    expect_retire(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_basic();
    t_single();
    t_full();
    t_ready_one();
    t_flush_head();
    t_flush_second();
    t_stale_finish();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule